// File: doc/BRIEF.md
# Multi-Bit Word Serializer

This block turns an 8-bit parallel word into a stream of serial bits for the transmit side of a serial-peripheral master. A word is taken in with a load strobe and then leaves through a narrow output, `STEP_W` bits per accepted shift step. The bit order, least or most significant first, is chosen per word by a mode input that is captured together with the data.

The block sorts out the interaction between load and shift requests. A load outranks a shift when both arrive together. A load is refused while any part of the current word is still waiting to go out, and the busy output lets the producer hold its word until it can be taken. A stall input freezes the whole block without losing either the word being shifted or the position reached within it. The positions that shifting empties are refilled from a serial-in input, or with zeros when the parameter selects that. A valid output marks the cycles in which the bits on the serial output are being consumed.

Top module: `word_serializer`

## Requirements
- R1: After synchronous reset the serial output is all zeros, and busy and valid are low.
- R2: A load that is not stalled, made while busy is low, captures `data_i`. Busy rises on the next clock edge and stays high for exactly 8/STEP_W accepted shift steps.
- R3: A load requested while busy is high is refused. The word being shifted, its bit order and the remaining step count do not change.
- R4: When busy is low and load and shift are requested in the same cycle, the load is taken and the shift has no effect.
- R5: With `lsb_first_i`=1 at load, each step presents the next STEP_W bits in ascending significance. `ser_o[0]` carries the earliest bit, and the first step shows `data_i[STEP_W-1:0]`.
- R6: With `lsb_first_i`=0 at load, each step presents the next STEP_W bits in descending significance. `ser_o[STEP_W-1]` carries the earliest bit, and the first step shows `data_i[7:8-STEP_W]`.
- R7: The bit order is captured at load. Changing `lsb_first_i` in the middle of a word has no effect on that word.
- R8: While `stall_i` is high, loads and shifts are ignored and the register, order and count hold. No bit is lost or repeated once the stall is released.
- R9: `valid_o` is high exactly in cycles where busy is high, `shift_i` is high and `stall_i` is low.
- R10: Each accepted shift moves the `ser_in_i` value of that cycle into the vacated positions, so those bits follow the remaining data bits in output order. With the zero-fill variant the vacated positions fill with zeros.
- R11: A shift request while busy is low leaves the output, busy and the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Request to capture `data_i` |
| data_i | input | 8 | Parallel word to serialize |
| shift_i | input | 1 | Request to advance one step |
| lsb_first_i | input | 1 | Bit order for the word being loaded: 1 least significant first |
| stall_i | input | 1 | Freezes all state while high |
| ser_in_i | input | STEP_W | Fill bits moved in on each shift |
| ser_o | output | STEP_W | Bits of the current step |
| busy_o | output | 1 | Word in progress; loads are refused |
| valid_o | output | 1 | Current step's bits are being consumed this cycle |

## Verification
`ser_o` and `busy_o` are register outputs. They reflect a load or shift accepted at a rising edge from that edge onward, so a stimulus applied in cycle N shows up in cycle N+1. `valid_o` is combinational from the current inputs and busy, so it is due in the same cycle as the shift request. The bench drives inputs just after each rising edge and compares all three outputs at the following falling edge against a behavioural queue model, updating the model only after that compare. Each comparison therefore sees the state that the previous edge produced, together with the inputs of the current cycle.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int SER_DATA_W = 8;

    typedef enum logic {
        ORD_MSB = 1'b0,
        ORD_LSB = 1'b1
    } ser_order_e;

    typedef struct packed {
        logic load_go;
        logic shift_go;
    } ser_grant_t;

endpackage

// File: rtl/ser_arbiter.sv
module ser_arbiter
    import ser_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       shift_i,
    input  logic       stall_i,
    output ser_grant_t grant_o,
    output logic       busy_o
);
    localparam int STEPS = SER_DATA_W / STEP_W;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy;

    assign busy = (cnt_q != '0);

    always_comb begin
        grant_o.load_go  = load_i && !stall_i && !busy;
        grant_o.shift_go = shift_i && !stall_i && busy && !grant_o.load_go;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (grant_o.load_go) begin
            cnt_q <= CNT_W'(STEPS);
        end else if (grant_o.shift_go) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy;

    AST_LOAD_ARMS_COUNT: assert property (@(posedge clk) disable iff (rst)
        grant_o.load_go |=> (cnt_q == CNT_W'(STEPS))); // R2
    AST_STALL_FREEZES_COUNT: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(cnt_q)); // R8
    AST_IDLE_SHIFT_NOP: assert property (@(posedge clk) disable iff (rst)
        (!busy && shift_i && !load_i) |=> (cnt_q == '0)); // R11
    AST_BUSY_REFUSES_LOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && load_i && !shift_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/ser_shreg.sv
module ser_shreg
    import ser_pkg::*;
#(
    parameter int STEP_W          = 2,
    parameter bit FILL_FROM_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  ser_grant_t        grant_i,
    input  logic [7:0]        data_i,
    input  logic              lsb_first_i,
    input  logic [STEP_W-1:0] ser_in_i,
    output logic [STEP_W-1:0] ser_o
);
    localparam int DW = SER_DATA_W;

    logic [DW-1:0]     word_q, word_d;
    ser_order_e        order_q, order_d;
    logic [STEP_W-1:0] fill;

    generate
        if (FILL_FROM_INPUT) begin : g_fill_in
            assign fill = ser_in_i;
        end else begin : g_fill_zero
            logic unused_fill;
            assign unused_fill = ^ser_in_i;
            assign fill = '0;
        end
    endgenerate

    always_comb begin
        word_d  = word_q;
        order_d = order_q;
        if (grant_i.load_go) begin
            word_d  = data_i;
            order_d = lsb_first_i ? ORD_LSB : ORD_MSB;
        end else if (grant_i.shift_go) begin
            if (order_q == ORD_LSB) begin
                word_d = {fill, word_q[DW-1:STEP_W]};
            end else begin
                word_d = {word_q[DW-STEP_W-1:0], fill};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            order_q <= ORD_MSB;
        end else begin
            word_q  <= word_d;
            order_q <= order_d;
        end
    end

    assign ser_o = (order_q == ORD_LSB) ? word_q[STEP_W-1:0] : word_q[DW-1 -: STEP_W];

    AST_WORD_HOLDS_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!grant_i.load_go && !grant_i.shift_go) |=> ($stable(word_q) && $stable(order_q))); // R8
    AST_ORDER_KEPT_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
        grant_i.shift_go |=> $stable(order_q)); // R7
    AST_LOAD_CAPTURES_WORD: assert property (@(posedge clk) disable iff (rst)
        grant_i.load_go |=> (word_q == $past(data_i))); // R2

endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import ser_pkg::*;
#(
    parameter int STEP_W          = 2,
    parameter bit FILL_FROM_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [7:0]        data_i,
    input  logic              shift_i,
    input  logic              lsb_first_i,
    input  logic              stall_i,
    input  logic [STEP_W-1:0] ser_in_i,
    output logic [STEP_W-1:0] ser_o,
    output logic              busy_o,
    output logic              valid_o
);
    ser_grant_t grant;

    ser_arbiter #(.STEP_W(STEP_W)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .shift_i (shift_i),
        .stall_i (stall_i),
        .grant_o (grant),
        .busy_o  (busy_o)
    );

    ser_shreg #(.STEP_W(STEP_W), .FILL_FROM_INPUT(FILL_FROM_INPUT)) shreg_i (
        .clk         (clk),
        .rst         (rst),
        .grant_i     (grant),
        .data_i      (data_i),
        .lsb_first_i (lsb_first_i),
        .ser_in_i    (ser_in_i),
        .ser_o       (ser_o)
    );

    assign valid_o = grant.shift_go;

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (busy_o && shift_i && !stall_i)); // R9
    AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(ser_o) && $stable(busy_o))); // R8
    AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && load_i && shift_i && !stall_i) |=> busy_o); // R4

endmodule

// File: tb/word_serializer_tb_top.sv
module word_serializer_tb_top;
    localparam int STEP_W = 2;
    localparam int DW     = 8;
    localparam int STEPS  = DW / STEP_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              load_i;
    logic [7:0]        data_i;
    logic              shift_i;
    logic              lsb_first_i;
    logic              stall_i;
    logic [STEP_W-1:0] ser_in_i;
    logic [STEP_W-1:0] ser_o;
    logic              busy_o;
    logic              valid_o;

    always #2 clk = ~clk;

    word_serializer #(.STEP_W(STEP_W), .FILL_FROM_INPUT(1'b1)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .data_i      (data_i),
        .shift_i     (shift_i),
        .lsb_first_i (lsb_first_i),
        .stall_i     (stall_i),
        .ser_in_i    (ser_in_i),
        .ser_o       (ser_o),
        .busy_o      (busy_o),
        .valid_o     (valid_o)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    bit q[$];
    bit m_lsb;
    int m_cnt;

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < DW; i++) q.push_back(1'b0);
        m_lsb = 1'b0;
        m_cnt = 0;
    endtask

    task automatic step(input bit ld, input logic [7:0] d, input bit sh, input bit lsb,
                        input bit st, input logic [STEP_W-1:0] sin, input string tag);
        logic [STEP_W-1:0] exp_ser;
        bit exp_busy, exp_valid;
        load_i = ld; data_i = d; shift_i = sh; lsb_first_i = lsb; stall_i = st; ser_in_i = sin;
        @(negedge clk);
        for (int i = 0; i < STEP_W; i++) begin
            if (m_lsb) exp_ser[i] = q[i];
            else       exp_ser[STEP_W-1-i] = q[i];
        end
        exp_busy  = (m_cnt != 0);
        exp_valid = exp_busy && sh && !st;
        vectors++;
        if (ser_o !== exp_ser) begin
            misses++;
            $display("FAIL %s ser_o actual=%b expected=%b", tag, ser_o, exp_ser);
        end
        if (busy_o !== exp_busy) begin
            misses++;
            $display("FAIL %s busy_o actual=%b expected=%b", tag, busy_o, exp_busy);
        end
        if (valid_o !== exp_valid) begin
            misses++;
            $display("FAIL %s/R9 valid_o actual=%b expected=%b", tag, valid_o, exp_valid);
        end
        if (!st) begin
            if (ld && !exp_busy) begin
                q.delete();
                for (int i = 0; i < DW; i++) q.push_back(lsb ? d[i] : d[DW-1-i]);
                m_lsb = lsb;
                m_cnt = STEPS;
            end else if (sh && exp_busy) begin
                for (int i = 0; i < STEP_W; i++) void'(q.pop_front());
                for (int i = 0; i < STEP_W; i++) q.push_back(m_lsb ? sin[i] : sin[STEP_W-1-i]);
                m_cnt--;
            end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_i = 0; data_i = 0; shift_i = 0; lsb_first_i = 0; stall_i = 0; ser_in_i = 0;
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        step(0, 8'h00, 0, 0, 0, 2'b00, "R1");
        // R5: LSB-first word with fill bits (R10)
        step(1, 8'hB4, 0, 1, 0, 2'b00, "R2");
        step(0, 8'h00, 1, 1, 0, 2'b01, "R5");
        step(0, 8'h00, 1, 1, 0, 2'b10, "R5");
        step(0, 8'h00, 1, 1, 0, 2'b11, "R5");
        step(0, 8'h00, 1, 1, 0, 2'b00, "R5");
        step(0, 8'h00, 0, 1, 0, 2'b00, "R10");
        step(0, 8'h00, 1, 0, 0, 2'b11, "R11");
        step(0, 8'h00, 0, 0, 0, 2'b00, "R11");
        // R6: MSB-first with stalls, order toggle, refused load
        step(1, 8'h9C, 0, 0, 0, 2'b00, "R6");
        step(0, 8'h00, 1, 0, 0, 2'b10, "R6");
        step(1, 8'hFF, 1, 1, 1, 2'b11, "R8");
        step(1, 8'hFF, 1, 1, 1, 2'b01, "R8");
        step(1, 8'h55, 0, 1, 0, 2'b00, "R3");
        step(0, 8'h00, 1, 1, 0, 2'b01, "R7");
        step(1, 8'h33, 1, 0, 0, 2'b11, "R3");
        step(0, 8'h00, 1, 1, 0, 2'b00, "R7");
        step(0, 8'h00, 0, 0, 0, 2'b00, "R10");
        // R4: load and shift together while idle
        step(1, 8'hA7, 1, 0, 0, 2'b00, "R4");
        step(0, 8'h00, 0, 0, 0, 2'b00, "R4");
        step(1, 8'h00, 1, 1, 1, 2'b00, "R8");
        for (int k = 0; k < STEPS; k++) step(0, 8'h00, 1, 0, 0, 2'(k), "R2");
        step(0, 8'h00, 0, 0, 0, 2'b00, "R2");
        // random mix
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 4) == 0, 8'($urandom), ($urandom % 3) != 0, 1'($urandom),
                 ($urandom % 5) == 0, 2'($urandom), "RND");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule